// File: doc/BRIEF.md
# Speculative Lock Elision Buffer

This block sits between one hardware thread's memory-operation stream and its memory write path. It lets a spin-lock be taken speculatively. When the thread executes an exchange or locked read-modify-write that carries an acquire hint, the block opens a transaction instead of writing the lock. It records three values in a private one-entry buffer: the lock address, the value the lock held, and the value the thread meant to write. The write is kept off the memory path, so other threads still see the lock as free and can enter the same critical section in parallel.

While the transaction is open, the thread's own loads of the lock address see the buffered value, so the thread sees the lock as taken. A write from another agent anywhere in the lock's cache line aborts the transaction, because the lock belongs to the read set. A pause instruction or an abort from the surrounding transactional logic also aborts it. A release-hinted store that puts the original value back is dropped, and the transaction commits. After any abort, the next acquire hint is ignored so that the retried lock instruction really writes the lock. With elision disabled by parameter, both hints have no effect.

Top module: `lock_elision_buffer`

## Requirements
- R1: Operation kinds are encoded on `op_kind` as 0 load, 1 store, 2 exchange, 3 locked read-modify-write, 4 pause, 5 no-op. Hints are encoded on `op_hint` as 0 none, 1 acquire, 2 release. An exchange or read-modify-write with the acquire hint, issued while no transaction is open and no retry is pending, produces no memory write. `txn_active` is high from the next cycle.
- R2: While a transaction is open, operations that are neither the lock release nor a pause pass to the memory write path unchanged. Plain stores are one example. `txn_active` stays high.
- R3: While a transaction is open, a load whose address equals the lock address exactly returns the buffered new value on `core_rdata`. Every other load, and every load made while no transaction is open, returns `mem_rdata`.
- R4: While a transaction is open, a snooped write (`snp_valid` and `snp_write`) to any address in the lock's line (the same address bits above the low LINE_W bits, 6 by default) aborts it. Snooped reads and snooped writes to other lines have no effect.
- R5: A release-hinted store, exchange or read-modify-write to the exact lock address, while a transaction is open, whose data equals the saved original value produces no memory write and commits. A release hint to any other address, or one issued with no transaction open, is an ordinary write and does not commit.
- R6: After an abort, the next acquire-hinted exchange or read-modify-write is performed as an ordinary write and opens no transaction. The acquire after that one elides again.
- R7: A release to the lock address whose data differs from the saved original value is written to memory and still commits.
- R8: A pause issued while a transaction is open aborts it. A pause issued with no transaction open has no effect.
- R9: An acquire hint on a load, store or pause is ignored, and a store carrying it is written normally.
- R10: With ELISION_EN set to 0, no hint suppresses a write and `txn_active` stays low.
- R11: `abort_in` aborts an open transaction. With no transaction open it has no effect and sets no pending retry.
- R12: After reset, `txn_active`, `commit_pulse` and `abort_pulse` are low. Each outcome pulse lasts one cycle, comes the cycle after its cause, and the two never assert together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation kind (encoding in R1) |
| op_hint | input | 2 | Elision hint (encoding in R1) |
| op_addr | input | ADDR_W | Operation address |
| op_wdata | input | DATA_W | Data the operation would write |
| mem_rdata | input | DATA_W | Current memory value at op_addr |
| snp_valid | input | 1 | Another agent's access is observed |
| snp_write | input | 1 | The observed access is a write |
| snp_addr | input | ADDR_W | Address of the observed access |
| abort_in | input | 1 | Abort request from the transactional logic |
| mem_wr_en | output | 1 | Write forwarded to memory |
| mem_wr_addr | output | ADDR_W | Forwarded write address |
| mem_wr_data | output | DATA_W | Forwarded write data |
| core_rdata | output | DATA_W | Read data returned to the thread |
| txn_active | output | 1 | Elided transaction is open |
| commit_pulse | output | 1 | Transaction committed |
| abort_pulse | output | 1 | Transaction aborted |

## Verification
The acquire path is driven in four situations: a clean first attempt, the retry after a snooped write, the retry after a pause, and the retry after an external abort. This separates the elided write from the real one and shows that the retry flag clears after a single use. Releases are sent with the original value, with a different value, to a neighbouring address in the same line, and with no transaction open, so suppression, commit and ordinary writes can each be told apart. Snoops are placed in the lock's line and outside it, as reads and as writes, to pin down the read-set granularity. The same stream drives a second instance built with elision disabled.

// File: rtl/leb_pkg.sv
package leb_pkg;

   typedef enum logic [2:0] {
      OP_LOAD  = 3'd0,
      OP_STORE = 3'd1,
      OP_SWAP  = 3'd2,
      OP_RMW   = 3'd3,
      OP_PAUSE = 3'd4,
      OP_NOP   = 3'd5
   } op_kind_e;

   typedef enum logic [1:0] {
      HINT_NONE = 2'd0,
      HINT_TAKE = 2'd1,
      HINT_DROP = 2'd2
   } hint_e;

   // Operation kinds that place data on the memory write path
   function automatic logic kind_writes(input logic [2:0] k);
      return (k == OP_STORE) || (k == OP_SWAP) || (k == OP_RMW);
   endfunction

   // Kinds on which an acquire hint is honoured
   function automatic logic kind_takes(input logic [2:0] k);
      return (k == OP_SWAP) || (k == OP_RMW);
   endfunction

endpackage

// File: rtl/leb_capture.sv
module leb_capture #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] orig_in,
   input  logic [DATA_W-1:0] new_in,
   output logic [ADDR_W-1:0] lock_addr,
   output logic [DATA_W-1:0] orig_val,
   output logic [DATA_W-1:0] new_val
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_addr <= '0;
         orig_val  <= '0;
         new_val   <= '0;
      end else if (load_en) begin
         lock_addr <= addr_in;
         orig_val  <= orig_in;
         new_val   <= new_in;
      end
   end

endmodule

// File: rtl/leb_ctrl.sv
module leb_ctrl
   import leb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LINE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_kind,
   input  logic [1:0]        op_hint,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              abort_in,
   input  logic [ADDR_W-1:0] lock_addr,
   input  logic [DATA_W-1:0] orig_val,
   output logic              start,
   output logic              elide_wr,
   output logic              fwd_hit,
   output logic              txn_active,
   output logic              commit_pulse,
   output logic              abort_pulse
);

   localparam int TAG_LO = LINE_W;

   logic active_q, skip_q, commit_q, abort_q;
   logic take_ok, drop_ok, same_lock, snoop_hit;
   logic pause_ab, snoop_ab, any_ab, commit_now, consume_skip;

   always_comb begin
      same_lock    = (op_addr == lock_addr);
      take_ok      = op_valid && (op_hint == HINT_TAKE) && kind_takes(op_kind);
      drop_ok      = op_valid && (op_hint == HINT_DROP) && kind_writes(op_kind)
                     && active_q && same_lock;
      snoop_hit    = snp_valid && snp_write
                     && (snp_addr[ADDR_W-1:TAG_LO] == lock_addr[ADDR_W-1:TAG_LO]);
      start        = take_ok && !active_q && !skip_q;
      consume_skip = take_ok && !active_q && skip_q;
      pause_ab     = active_q && op_valid && (op_kind == OP_PAUSE);
      snoop_ab     = active_q && snoop_hit;
      any_ab       = pause_ab || snoop_ab || (active_q && abort_in);
      commit_now   = drop_ok && !any_ab;
      elide_wr     = start || (drop_ok && (op_wdata == orig_val));
      fwd_hit      = active_q && op_valid && (op_kind == OP_LOAD) && same_lock;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         skip_q   <= 1'b0;
         commit_q <= 1'b0;
         abort_q  <= 1'b0;
      end else begin
         commit_q <= commit_now;
         abort_q  <= any_ab;
         if (start)                    active_q <= 1'b1;
         else if (any_ab || commit_now) active_q <= 1'b0;
         if (any_ab)                   skip_q <= 1'b1;
         else if (consume_skip)        skip_q <= 1'b0;
      end
   end

   assign txn_active   = active_q;
   assign commit_pulse = commit_q;
   assign abort_pulse  = abort_q;

   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> txn_active); // R1
   AST_SNOOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_active && snp_valid && snp_write
       && snp_addr[ADDR_W-1:TAG_LO] == lock_addr[ADDR_W-1:TAG_LO])
      |=> (abort_pulse && !txn_active)); // R4
   AST_PAUSE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_active && op_valid && op_kind == OP_PAUSE) |=> abort_pulse); // R8
   AST_RETRY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (skip_q && !txn_active)); // R6
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_pulse && abort_pulse)); // R12

endmodule

// File: rtl/leb_datapath.sv
module leb_datapath
   import leb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              op_valid,
   input  logic [2:0]        op_kind,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              elide_wr,
   input  logic              fwd_hit,
   input  logic [DATA_W-1:0] new_val,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic [DATA_W-1:0] core_rdata
);

   always_comb begin
      mem_wr_en   = op_valid && kind_writes(op_kind) && !elide_wr;
      mem_wr_addr = op_addr;
      mem_wr_data = op_wdata;
      core_rdata  = fwd_hit ? new_val : mem_rdata;
   end

   always_comb begin
      if (fwd_hit) begin
         AST_FWD_READ_ONLY: assert (!mem_wr_en); // R3
      end
   end

endmodule

// File: rtl/lock_elision_buffer.sv
module lock_elision_buffer
   import leb_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 32,
   parameter int LINE_W     = 6,
   parameter bit ELISION_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_kind,
   input  logic [1:0]        op_hint,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic              abort_in,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data,
   output logic [DATA_W-1:0] core_rdata,
   output logic              txn_active,
   output logic              commit_pulse,
   output logic              abort_pulse
);

   initial begin
      AST_PARAM_ADDR: assert (ADDR_W >= 2) else $error("ADDR_W too small");
      AST_PARAM_DATA: assert (DATA_W >= 1) else $error("DATA_W too small");
      AST_PARAM_LINE: assert (LINE_W >= 0 && LINE_W < ADDR_W)
         else $error("LINE_W must be below ADDR_W");
   end

   logic              start, elide_wr, fwd_hit;
   logic [ADDR_W-1:0] lock_addr;
   logic [DATA_W-1:0] orig_val, new_val;

   generate
      if (ELISION_EN) begin : g_elide
         leb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_en   (start),
            .addr_in   (op_addr),
            .orig_in   (mem_rdata),
            .new_in    (op_wdata),
            .lock_addr (lock_addr),
            .orig_val  (orig_val),
            .new_val   (new_val)
         );

         leb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W)) u_ctrl (
            .clk          (clk),
            .rst_n        (rst_n),
            .op_valid     (op_valid),
            .op_kind      (op_kind),
            .op_hint      (op_hint),
            .op_addr      (op_addr),
            .op_wdata     (op_wdata),
            .snp_valid    (snp_valid),
            .snp_write    (snp_write),
            .snp_addr     (snp_addr),
            .abort_in     (abort_in),
            .lock_addr    (lock_addr),
            .orig_val     (orig_val),
            .start        (start),
            .elide_wr     (elide_wr),
            .fwd_hit      (fwd_hit),
            .txn_active   (txn_active),
            .commit_pulse (commit_pulse),
            .abort_pulse  (abort_pulse)
         );
      end else begin : g_plain
         logic unused_in;
         assign unused_in    = ^{clk, rst_n, op_hint, snp_valid, snp_write,
                                 snp_addr, abort_in};
         assign start        = 1'b0;
         assign elide_wr     = 1'b0;
         assign fwd_hit      = 1'b0;
         assign lock_addr    = '0;
         assign orig_val     = '0;
         assign new_val      = '0;
         assign txn_active   = 1'b0;
         assign commit_pulse = 1'b0;
         assign abort_pulse  = 1'b0;
      end
   endgenerate

   leb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_datapath (
      .op_valid    (op_valid),
      .op_kind     (op_kind),
      .op_addr     (op_addr),
      .op_wdata    (op_wdata),
      .mem_rdata   (mem_rdata),
      .elide_wr    (elide_wr),
      .fwd_hit     (fwd_hit),
      .new_val     (new_val),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_addr (mem_wr_addr),
      .mem_wr_data (mem_wr_data),
      .core_rdata  (core_rdata)
   );

   AST_ELIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !mem_wr_en); // R1
   AST_PLAIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ELISION_EN |-> !txn_active); // R10

endmodule

// File: tb/lock_elision_buffer_tb.sv
module lock_elision_buffer_tb;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam logic [AW-1:0] LA = 16'h0040;

   typedef struct {
      logic [2:0]    kind;
      logic          wr_en;
      logic [AW-1:0] wr_addr;
      logic [DW-1:0] wr_data;
      logic [DW-1:0] rdata;
      logic          active;
      logic          commit;
      logic          abort;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [2:0]    op_kind = 3'd5;
   logic [1:0]    op_hint = 2'd0;
   logic [AW-1:0] op_addr = '0;
   logic [DW-1:0] op_wdata = '0;
   logic [DW-1:0] mem_rdata = '0;
   logic          snp_valid = 1'b0;
   logic          snp_write = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          abort_in = 1'b0;

   logic          mem_wr_en, commit_pulse, abort_pulse, txn_active;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data, core_rdata;
   logic          off_wr_en, off_commit, off_abort, off_active;
   logic [AW-1:0] off_wr_addr;
   logic [DW-1:0] off_wr_data, off_rdata;

   int n_cmp = 0;
   int n_bad = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   lock_elision_buffer #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_hint(op_hint), .op_addr(op_addr), .op_wdata(op_wdata),
      .mem_rdata(mem_rdata), .snp_valid(snp_valid), .snp_write(snp_write),
      .snp_addr(snp_addr), .abort_in(abort_in), .mem_wr_en(mem_wr_en),
      .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .core_rdata(core_rdata), .txn_active(txn_active),
      .commit_pulse(commit_pulse), .abort_pulse(abort_pulse));

   lock_elision_buffer #(.ADDR_W(AW), .DATA_W(DW), .ELISION_EN(1'b0)) u_dut_off (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .op_hint(op_hint), .op_addr(op_addr), .op_wdata(op_wdata),
      .mem_rdata(mem_rdata), .snp_valid(snp_valid), .snp_write(snp_write),
      .snp_addr(snp_addr), .abort_in(abort_in), .mem_wr_en(off_wr_en),
      .mem_wr_addr(off_wr_addr), .mem_wr_data(off_wr_data),
      .core_rdata(off_rdata), .txn_active(off_active),
      .commit_pulse(off_commit), .abort_pulse(off_abort));

   task automatic chk(input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Driver: presents one operation and pushes what it must produce
   task automatic drive(input logic [2:0] k, input logic [1:0] h,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] md, input logic sv, input logic sw,
                        input logic [AW-1:0] sa, input logic ab,
                        input logic e_wr, input logic [DW-1:0] e_rd,
                        input logic e_act, input logic e_com, input logic e_ab,
                        input string tag);
      exp_t e;
      @(negedge clk);
      op_valid = 1'b1; op_kind = k; op_hint = h; op_addr = a; op_wdata = wd;
      mem_rdata = md; snp_valid = sv; snp_write = sw; snp_addr = sa;
      abort_in = ab;
      e.kind = k; e.wr_en = e_wr; e.wr_addr = a; e.wr_data = wd; e.rdata = e_rd;
      e.active = e_act; e.commit = e_com; e.abort = e_ab; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      op_valid = 1'b0; op_kind = 3'd5; op_hint = 2'd0; snp_valid = 1'b0;
      snp_write = 1'b0; abort_in = 1'b0;
   endtask

   // Monitor: pops the expected item for the operation on the bus
   initial begin
      forever begin
         @(negedge clk);
         #5;
         if (q.size() > 0) begin
            exp_t e;
            logic off_exp;
            e = q.pop_front();
            chk(e.tag, "mem_wr_en", {31'd0, mem_wr_en}, {31'd0, e.wr_en});
            if (e.wr_en) begin
               chk(e.tag, "mem_wr_addr", {16'd0, mem_wr_addr}, {16'd0, e.wr_addr});
               chk(e.tag, "mem_wr_data", mem_wr_data, e.wr_data);
            end
            chk(e.tag, "core_rdata", core_rdata, e.rdata);
            // R10: disabled instance writes every writing kind
            off_exp = (e.kind == 3'd1) || (e.kind == 3'd2) || (e.kind == 3'd3);
            chk("R10", "off mem_wr_en", {31'd0, off_wr_en}, {31'd0, off_exp});
            @(posedge clk);
            #1;
            chk(e.tag, "txn_active", {31'd0, txn_active}, {31'd0, e.active});
            chk(e.tag, "commit_pulse", {31'd0, commit_pulse}, {31'd0, e.commit});
            chk(e.tag, "abort_pulse", {31'd0, abort_pulse}, {31'd0, e.abort});
            chk("R10", "off txn_active", {31'd0, off_active}, 32'd0);
         end
      end
   end

   initial begin
      #4000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   // kinds: 0 load 1 store 2 swap 3 rmw 4 pause 5 nop; hints: 0 none 1 acq 2 rel
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R12", "reset txn_active", {31'd0, txn_active}, 32'd0);
      chk("R12", "reset commit", {31'd0, commit_pulse}, 32'd0);
      chk("R12", "reset abort", {31'd0, abort_pulse}, 32'd0);
      //     k  h  addr     wd md sv sw sa       ab wr rd act com ab
      drive(0, 0, 16'h10,  0, 7, 0, 0, 0,       0, 0, 7, 0, 0, 0, "R3");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 0, 0, 1, 0, 0, "R1");
      drive(0, 0, LA,      0, 0, 0, 0, 0,       0, 0, 1, 1, 0, 0, "R3");
      drive(0, 0, 16'h44,  0, 9, 0, 0, 0,       0, 0, 9, 1, 0, 0, "R3");
      drive(1, 0, 16'h20,  5, 0, 0, 0, 0,       0, 1, 0, 1, 0, 0, "R2");
      drive(5, 0, 0,       0, 0, 1, 0, LA,      0, 0, 0, 1, 0, 0, "R4");
      drive(5, 0, 0,       0, 0, 1, 1, 16'h100, 0, 0, 0, 1, 0, 0, "R4");
      drive(1, 2, 16'h50,  0, 0, 0, 0, 0,       0, 1, 0, 1, 0, 0, "R5");
      drive(1, 2, LA,      0, 0, 0, 0, 0,       0, 0, 0, 0, 1, 0, "R5");
      drive(0, 0, LA,      0, 0, 0, 0, 0,       0, 0, 0, 0, 0, 0, "R3");
      drive(3, 1, LA,      1, 0, 0, 0, 0,       0, 0, 0, 1, 0, 0, "R1");
      drive(5, 0, 0,       0, 0, 1, 1, 16'h7C,  0, 0, 0, 0, 0, 1, "R4");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 1, 0, 0, 0, 0, "R6");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 0, 0, 1, 0, 0, "R6");
      drive(4, 0, 0,       0, 0, 0, 0, 0,       0, 0, 0, 0, 0, 1, "R8");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 1, 0, 0, 0, 0, "R6");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 0, 0, 1, 0, 0, "R1");
      drive(2, 2, LA,      2, 0, 0, 0, 0,       0, 1, 0, 0, 1, 0, "R7");
      drive(1, 1, LA,      1, 0, 0, 0, 0,       0, 1, 0, 0, 0, 0, "R9");
      drive(0, 1, LA,      0, 3, 0, 0, 0,       0, 0, 3, 0, 0, 0, "R9");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 0, 0, 1, 0, 0, "R1");
      drive(5, 0, 0,       0, 0, 0, 0, 0,       1, 0, 0, 0, 0, 1, "R11");
      drive(4, 0, 0,       0, 0, 0, 0, 0,       0, 0, 0, 0, 0, 0, "R8");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 1, 0, 0, 0, 0, "R6");
      drive(1, 2, LA,      0, 0, 0, 0, 0,       0, 1, 0, 0, 0, 0, "R5");
      drive(5, 0, 0,       0, 0, 0, 0, 0,       1, 0, 0, 0, 0, 0, "R11");
      drive(2, 1, LA,      1, 0, 0, 0, 0,       0, 0, 0, 1, 0, 0, "R11");
      drive(2, 2, LA,      0, 0, 0, 0, 0,       0, 0, 0, 0, 1, 0, "R5");
      drive(5, 0, 0,       0, 0, 0, 0, 0,       0, 0, 0, 0, 0, 0, "R12");
      idle();
      repeat (3) idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule